// File: doc/BRIEF.md
# Per-Target Interrupt Priority Selector

This block serves one interrupt target. Each cycle it looks at which sources are pending and which are enabled for this target. From those candidates it picks the one with the highest priority. It registers that source's number as the claimable ID. It also drives a request line that tells the target an interrupt deserves attention.

A source's number is its bit position in the input vectors. Number 0 is reserved to mean "nothing to claim". The target's threshold affects only the request line. The claimable ID follows the priority contest alone, so a target that claims below its threshold still receives the best candidate.

The block never alters pending state. Detecting edges and levels, clearing on claim, and the register file all sit elsewhere. The source count and the largest priority value are parameters.

Top module: `irq_target_arbiter`

## Requirements
- R1: The claim ID output carries the bit position of the winning source in `pendIn`/`enIn`.
- R2: A source takes part in the contest only when both its `pendIn` bit and its `enIn` bit are 1.
- R3: The candidate with the largest priority wins. When several candidates share that priority, the lowest bit position wins.
- R4: `irqOut` is 1 exactly when a candidate exists and the winner's priority is strictly greater than `thresholdIn`.
- R5: A winner with priority 0 never sets `irqOut`. A threshold equal to `MAX_PRIO` keeps `irqOut` at 0 for any inputs.
- R6: The claim ID does not depend on `thresholdIn`. A winner at or below the threshold is still reported, with `irqOut` at 0.
- R7: With no candidate, the claim ID is 0 and `irqOut` is 0.
- R8: Both outputs are registered. A change on any input appears at the outputs after the next rising clock edge, not before. While `rstN` is low, both outputs are 0.
- R9: Source 0 never wins, whatever its pending, enable or priority inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pendIn | input | NSRC | Pending flag per source, bit i is source i |
| enIn | input | NSRC | Enable per source for this target |
| prioIn | input | NSRC*PRIO_W | Priority of source i at bits [i*PRIO_W +: PRIO_W] |
| thresholdIn | input | PRIO_W | Target threshold |
| claimId | output | ID_W | Registered ID of the winning source, 0 if none |
| irqOut | output | 1 | Registered request line to the target |

## Verification
The bench exercises equal-priority contests. A design that favoured the higher ID there would hand out the wrong source.

It also checks a pending source that is masked by its enable bit, which a design reading only pending flags would report. It checks a winner whose priority equals the threshold, where a design using greater-or-equal would raise the request line. It checks a priority-0 winner, which should still be reported but must not raise the line.

Source 0 is driven pending, enabled and at top priority, so a design that does not exclude it returns ID 0 in place of the real winner. Outputs are also sampled between an input change and the next edge, to catch a design that passes results through combinationally.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic forceZero;  // no candidate: load ID 0
  } arbStrobe_t;
endpackage

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NSRC-1:0]        pendIn,
  input  logic [NSRC-1:0]        enIn,
  input  logic [NSRC*PRIO_W-1:0] prioIn,
  input  arbStrobe_t             strobe,
  output logic [PRIO_W-1:0]      winPrio,
  output logic                   anyCand,
  output logic [ID_W-1:0]        idQ
);
  logic [PRIO_W-1:0] prioArr [NSRC];
  logic [NSRC-1:0]   cand;
  logic [ID_W-1:0]   winId;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign prioArr[i] = prioIn[i*PRIO_W +: PRIO_W];
    if (i == 0) begin : g_rsvd
      assign cand[i] = 1'b0;
    end else begin : g_live
      assign cand[i] = pendIn[i] & enIn[i];
    end
  end

  // Scan from the top ID down; ">=" lets a lower ID take over on a tie.
  always_comb begin
    winId   = '0;
    winPrio = '0;
    anyCand = 1'b0;
    for (int i = NSRC - 1; i >= 1; i--) begin
      if (cand[i] && (!anyCand || prioArr[i] >= winPrio)) begin
        winId   = ID_W'(i);
        winPrio = prioArr[i];
        anyCand = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                idQ <= '0;
    else if (strobe.forceZero) idQ <= '0;
    else                      idQ <= winId;
  end

  // R7
  none_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past((pendIn[NSRC-1:1] & enIn[NSRC-1:1]) == '0) |-> idQ == '0);

  // R9
  src0_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(pendIn[0] & enIn[0] & ((pendIn[NSRC-1:1] & enIn[NSRC-1:1]) == '0))
      |-> idQ == '0);
endmodule

// File: rtl/irq_arb_control.sv
module irq_arb_control
  import irq_arb_pkg::*;
#(
  parameter int PRIO_W   = 3,
  parameter int MAX_PRIO = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PRIO_W-1:0] winPrio,
  input  logic              anyCand,
  input  logic [PRIO_W-1:0] thresholdIn,
  output arbStrobe_t        strobe,
  output logic              irqQ
);
  logic notifyNext;

  assign strobe.forceZero = !anyCand;
  assign notifyNext       = anyCand && (winPrio > thresholdIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= notifyNext;
  end

  // R4
  irq_needs_cand_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> $past(anyCand));

  // R5
  thr_max_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(thresholdIn == PRIO_W'(MAX_PRIO)) |-> !irqQ);

  // R5
  zero_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(winPrio == '0) |-> !irqQ);
endmodule

// File: rtl/irq_target_arbiter.sv
module irq_target_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NSRC     = 32,
  parameter int MAX_PRIO = 7,
  localparam int PRIO_W  = $clog2(MAX_PRIO + 1),
  localparam int ID_W    = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NSRC-1:0]        pendIn,
  input  logic [NSRC-1:0]        enIn,
  input  logic [NSRC*PRIO_W-1:0] prioIn,
  input  logic [PRIO_W-1:0]      thresholdIn,
  output logic [ID_W-1:0]        claimId,
  output logic                   irqOut
);
  arbStrobe_t        strobe;
  logic [PRIO_W-1:0] winPrio;
  logic              anyCand;

  irq_arb_datapath #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) uData (
    .clk(clk), .rstN(rstN), .pendIn(pendIn), .enIn(enIn), .prioIn(prioIn),
    .strobe(strobe), .winPrio(winPrio), .anyCand(anyCand), .idQ(claimId)
  );

  irq_arb_control #(.PRIO_W(PRIO_W), .MAX_PRIO(MAX_PRIO)) uCtrl (
    .clk(clk), .rstN(rstN), .winPrio(winPrio), .anyCand(anyCand),
    .thresholdIn(thresholdIn), .strobe(strobe), .irqQ(irqOut)
  );
endmodule

// File: tb/tb_irq_target_arbiter.sv
module tb_irq_target_arbiter;
  localparam int NS = 32;
  localparam int PW = 3;

  typedef struct packed {
    logic [NS-1:0] pend;
    logic [NS-1:0] en;
    logic [PW-1:0] thr;
    logic [4:0]    expId;
    logic          expIrq;
  } vec_t;

  // Priority pattern: source i has priority i % 8.
  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0020, 32'hFFFF_FFFF, 3'd0, 5'd5,  1'b1}, // R1
    '{32'h0000_0060, 32'hFFFF_FFFF, 3'd0, 5'd6,  1'b1}, // R3
    '{32'h0000_8080, 32'hFFFF_FFFF, 3'd0, 5'd7,  1'b1}, // R3 tie
    '{32'h0000_8080, 32'h0000_8000, 3'd0, 5'd15, 1'b1}, // R2
    '{32'h0000_1008, 32'hFFFF_FFFF, 3'd4, 5'd12, 1'b0}, // R6
    '{32'h0000_1000, 32'hFFFF_FFFF, 3'd3, 5'd12, 1'b1}, // R4
    '{32'h0000_0100, 32'hFFFF_FFFF, 3'd0, 5'd8,  1'b0}, // R5 prio 0
    '{32'h0000_8000, 32'hFFFF_FFFF, 3'd7, 5'd15, 1'b0}, // R5 max thr
    '{32'h0000_0001, 32'hFFFF_FFFF, 3'd0, 5'd0,  1'b0}, // R9
    '{32'hFFFF_FFFF, 32'h0000_0000, 3'd0, 5'd0,  1'b0}, // R7
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd6, 5'd7,  1'b1}  // R3
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0]    pendIn = '0;
  logic [NS-1:0]    enIn = '0;
  logic [NS*PW-1:0] prioIn = '0;
  logic [PW-1:0]    thresholdIn = '0;
  logic [4:0]       claimId;
  logic             irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_target_arbiter dut (
    .clk(clk), .rstN(rstN), .pendIn(pendIn), .enIn(enIn), .prioIn(prioIn),
    .thresholdIn(thresholdIn), .claimId(claimId), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [4:0] expId, input logic expIrq);
    checks++;
    if (claimId !== expId || irqOut !== expIrq) begin
      errors++;
      $display("FAIL %s: id=%0d irq=%0b expected id=%0d irq=%0b",
               req, claimId, irqOut, expId, expIrq);
    end
  endtask

  function automatic logic [NS*PW-1:0] patPrio();
    logic [NS*PW-1:0] p;
    for (int i = 0; i < NS; i++) p[i*PW +: PW] = PW'(i % 8);
    return p;
  endfunction

  initial begin
    #3000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: id=%0d irq=%0b expected completion", claimId, irqOut);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    prioIn = patPrio();
    pendIn = '1; enIn = '1;
    repeat (3) @(posedge clk);
    #1 check("R8 reset", 5'd0, 1'b0);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    check("R3 first after reset", 5'd7, 1'b1);

    for (int v = 0; v < NV; v++) begin
      logic [4:0] prevId;
      logic       prevIrq;
      prevId = claimId; prevIrq = irqOut;
      @(negedge clk);
      pendIn = VEC[v].pend; enIn = VEC[v].en; thresholdIn = VEC[v].thr;
      #2 check("R8 latency", prevId, prevIrq);
      @(posedge clk); #1;
      check($sformatf("R1-table vector %0d", v), VEC[v].expId, VEC[v].expIrq);
    end

    // R9: source 0 at top priority loses to source 1 at priority 2.
    @(negedge clk);
    prioIn = '0;
    prioIn[0 +: PW] = 3'd7;
    prioIn[PW +: PW] = 3'd2;
    pendIn = 32'h3; enIn = 32'h3; thresholdIn = 3'd0;
    @(posedge clk); #1 check("R9 src0 top prio", 5'd1, 1'b1);

    // R6: same winner across thresholds, only irq changes.
    @(negedge clk) thresholdIn = 3'd2;
    @(posedge clk); #1 check("R6 thr equal", 5'd1, 1'b0);
    @(negedge clk) thresholdIn = 3'd1;
    @(posedge clk); #1 check("R4 thr below", 5'd1, 1'b1);

    // R8: asynchronous reset clears outputs.
    @(negedge clk) rstN = 1'b0;
    #2 check("R8 async reset", 5'd0, 1'b0);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1 check("R8 resume", 5'd1, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule